// File: doc/BRIEF.md
# Dual-Select Serial Register and FIFO Port

This block is a serial peripheral slave with two chip selects that share one clock line, one data input and one data output. While the register select is low, the block parses each frame as an address byte followed by data. A write pair produces one strobe on a register-file write port. A read turns every byte after the address into the next read address, and the addressed data streams back on the serial output.

While only the data select is low, the block works as a pointer-free streaming path to a FIFO. Each low-to-high framing of the select carries exactly one byte. That byte is pushed into the FIFO in write mode, or a byte is popped and shifted out in read mode.

The block also holds a sticky overrun flag. A push attempted into a full FIFO sets the flag. Writing a designated register clears both the flag and the FIFO. The serial inputs are assumed to be already synchronised to the system clock, and the serial clock runs at least four times slower than that clock.

Top module: `spi_dual_port`

## Requirements
- R1: After reset every strobe output (reg_wr, reg_rd, fifo_push, fifo_pop, fifo_clr), fifo_ovr and sdo_oe are 0.
- R2: With the register select low, the first byte (MSB first, sampled on SCK rising edges) is an address byte: bit 6 = 0 means write, bits 5..1 are the register address, bits 7 and 0 are ignored. The second byte produces one reg_wr pulse carrying that address and the byte as reg_wdata.
- R3: An address byte with bit 6 = 1 produces one reg_rd pulse with the address in bits 5..1. The reg_rdata value returned for it is shifted out on sdo MSB first during the next byte: bit 7 is present before the first rising edge, and sdo advances on each falling edge.
- R4: In read mode, every following byte in the same frame is taken as a new read address (bits 5..1). Each such byte produces its own reg_rd pulse, and its data is shifted out in the byte after it.
- R5: If the register select rises after only the address byte, no write occurs and the next frame starts again with an address byte.
- R6: In FIFO write mode (fifo_rd_mode = 0), a data-select frame with at least 8 bits produces exactly one fifo_push carrying the first 8 bits. Bits after the eighth are ignored, and a frame shorter than 8 bits pushes nothing.
- R7: In FIFO read mode (fifo_rd_mode = 1), the falling edge of the data select produces one fifo_pop, and the fifo_rdata byte is shifted out on sdo MSB first in that frame.
- R8: A byte that completes while fifo_full = 1 is not pushed and sets fifo_ovr. The flag stays set through later successful pushes.
- R9: A register write to address 0x0D with data bit 0 = 1 clears fifo_ovr and produces one fifo_clr pulse.
- R10: While the register select is low, the data select has no effect: no fifo_push and no fifo_pop occur, and the register transfer proceeds normally.
- R11: sdo_oe is 1 exactly while at least one select is low, and sdo is 0 while both selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, synchronised |
| sdi | input | 1 | Serial data in |
| cs_reg_n | input | 1 | Register select, active low |
| cs_fifo_n | input | 1 | FIFO data select, active low |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| fifo_rd_mode | input | 1 | 1 = pop FIFO on data select, 0 = push |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 5 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid while reg_rd is high |
| fifo_push | output | 1 | FIFO push strobe |
| fifo_wdata | output | 8 | FIFO push data |
| fifo_full | input | 1 | FIFO full indication |
| fifo_pop | output | 1 | FIFO pop strobe |
| fifo_rdata | input | 8 | FIFO head byte |
| fifo_ovr | output | 1 | Sticky overrun flag |
| fifo_clr | output | 1 | FIFO clear strobe |

## Verification
The bench targets several corner cases, each tied to a specific wrong behaviour:

- An address-only frame: a design that keeps its phase across the select would later treat an address as write data.
- A read frame that streams three addresses: a design that returns to address phase after one byte would emit a write instead of reads.
- FIFO frames of 12 and 5 bits: miscounting would give a double push or a push of a partial byte.
- Both selects asserted together: without priority, a stray push or pop would appear beside the register write.
- Overrun followed by a clearing write: a non-sticky flag, or a clear keyed on the wrong bit, shows up in fifo_ovr.

// File: rtl/spi_dual_port.sv
module spi_dual_port #(
  parameter int          AW       = 5,
  parameter logic [4:0]  OVR_ADDR = 5'h0D,
  parameter int          CLR_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          sdi,
  input  logic          cs_reg_n,
  input  logic          cs_fifo_n,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          fifo_rd_mode,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata,
  output logic          fifo_push,
  output logic [7:0]    fifo_wdata,
  input  logic          fifo_full,
  output logic          fifo_pop,
  input  logic [7:0]    fifo_rdata,
  output logic          fifo_ovr,
  output logic          fifo_clr
);

  logic       sck_q, reg_sel_q, fifo_sel_q;
  logic [2:0] cnt;
  logic [7:0] rx_sh, tx_sh;
  logic       data_ph, rd_mode, fdone;

  wire reg_sel  = ~cs_reg_n;
  wire fifo_sel = cs_reg_n & ~cs_fifo_n;
  wire any_sel  = reg_sel | fifo_sel;
  wire start    = (reg_sel & ~reg_sel_q) | (fifo_sel & ~fifo_sel_q);
  wire sck_rise = any_sel & sck & ~sck_q;
  wire sck_fall = any_sel & ~sck & sck_q;
  wire [7:0] rx_next = {rx_sh[6:0], sdi};

  assign sdo_oe = any_sel;
  assign sdo    = any_sel & tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; reg_sel_q <= 1'b0; fifo_sel_q <= 1'b0;
      cnt <= '0; rx_sh <= '0; tx_sh <= '0;
      data_ph <= 1'b0; rd_mode <= 1'b0; fdone <= 1'b0;
      reg_wr <= 1'b0; reg_rd <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      fifo_push <= 1'b0; fifo_wdata <= '0; fifo_pop <= 1'b0;
      fifo_ovr <= 1'b0; fifo_clr <= 1'b0;
    end else begin
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      fifo_push <= 1'b0;
      fifo_pop  <= 1'b0;
      fifo_clr  <= 1'b0;
      sck_q      <= sck;
      reg_sel_q  <= reg_sel;
      fifo_sel_q <= fifo_sel;
      if (!any_sel) begin
        cnt <= '0; data_ph <= 1'b0; fdone <= 1'b0; tx_sh <= '0;
      end else if (start) begin
        cnt <= '0; data_ph <= 1'b0; fdone <= 1'b0; tx_sh <= '0;
        if (fifo_sel && fifo_rd_mode) begin
          fifo_pop <= 1'b1;
          tx_sh    <= fifo_rdata;
        end
      end else begin
        if (reg_rd)
          tx_sh <= reg_rdata;
        else if (sck_fall && cnt != 3'd0)
          tx_sh <= {tx_sh[6:0], 1'b0};
        if (sck_rise) begin
          rx_sh <= rx_next;
          cnt   <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (reg_sel) begin
              if (!data_ph) begin
                reg_addr <= rx_next[AW:1];
                rd_mode  <= rx_next[6];
                data_ph  <= 1'b1;
                reg_rd   <= rx_next[6];
              end else if (rd_mode) begin
                reg_addr <= rx_next[AW:1];
                reg_rd   <= 1'b1;
              end else begin
                reg_wr    <= 1'b1;
                reg_wdata <= rx_next;
                data_ph   <= 1'b0;
                if (reg_addr == OVR_ADDR && rx_next[CLR_BIT]) begin
                  fifo_ovr <= 1'b0;
                  fifo_clr <= 1'b1;
                end
              end
            end else begin
              fdone <= 1'b1;
              if (!fifo_rd_mode && !fdone) begin
                if (fifo_full) fifo_ovr <= 1'b1;
                else begin
                  fifo_push  <= 1'b1;
                  fifo_wdata <= rx_next;
                end
              end
            end
          end
        end
      end
    end
  end

endmodule

module spi_dual_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_reg_n,
  input logic reg_wr,
  input logic reg_rd,
  input logic fifo_push,
  input logic fifo_pop,
  input logic fifo_full,
  input logic fifo_ovr,
  input logic fifo_clr
);
  // R2
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd));
  // R8
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n) fifo_push |-> $past(!fifo_full));
  // R8
  ovr_rise_full_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(fifo_ovr) |-> $past(fifo_full));
  // R9
  clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) fifo_clr |-> !fifo_ovr);
  // R10
  reg_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_reg_n && $past(!cs_reg_n)) |-> (!fifo_push && !fifo_pop));
endmodule

bind spi_dual_port spi_dual_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_reg_n(cs_reg_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_full(fifo_full),
  .fifo_ovr(fifo_ovr), .fifo_clr(fifo_clr)
);

// File: tb/test_spi_dual_port.sv
module test_spi_dual_port;
  logic clk = 0, rst_n = 0, sck = 0, sdi = 0, cs_reg_n = 1, cs_fifo_n = 1;
  logic fifo_rd_mode = 0, fifo_full = 0;
  logic [7:0] fifo_rdata = 8'h00;
  logic sdo, sdo_oe, reg_wr, reg_rd, fifo_push, fifo_pop, fifo_ovr, fifo_clr;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, fifo_wdata;
  int compared = 0, mismatched = 0;
  logic [12:0] q_wr[$];
  logic [4:0]  q_rd[$];
  logic [7:0]  q_push[$];
  int n_pop = 0, n_clr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rd_val(input logic [4:0] a);
    return {a, 3'b101} ^ 8'h5A;
  endfunction
  assign reg_rdata = rd_val(reg_addr);

  spi_dual_port i_spi_dual_port (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_reg_n(cs_reg_n), .cs_fifo_n(cs_fifo_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .fifo_rd_mode(fifo_rd_mode), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .fifo_full(fifo_full), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
    .fifo_ovr(fifo_ovr), .fifo_clr(fifo_clr));

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FIFO-PORT FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model queues
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk(sdo_oe, (!cs_reg_n || !cs_fifo_n), "R11 sdo_oe");
      if (cs_reg_n && cs_fifo_n) chk(sdo, 0, "R11 sdo idle");
      if (reg_wr) begin
        if (q_wr.size() == 0) chk({3'b0, reg_addr, reg_wdata}, 16'hFFFF, "R2/R5 unexpected write");
        else chk({3'b0, reg_addr, reg_wdata}, {3'b0, q_wr.pop_front()}, "R2 write port");
      end
      if (reg_rd) begin
        if (q_rd.size() == 0) chk(reg_addr, 16'hFFFF, "R3/R4 unexpected read");
        else chk(reg_addr, q_rd.pop_front(), "R3/R4 read address");
      end
      if (fifo_push) begin
        if (q_push.size() == 0) chk(fifo_wdata, 16'hFFFF, "R6/R8/R10 unexpected push");
        else chk(fifo_wdata, q_push.pop_front(), "R6 push data");
      end
      if (fifo_pop) begin
        chk(n_pop > 0, 1, "R7/R10 pop expected");
        n_pop--;
      end
      if (fifo_clr) begin
        chk(n_clr > 0, 1, "R9 clear expected");
        n_clr--;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] d, input int nb, output logic [7:0] r);
    r = 0;
    for (int i = 0; i < nb; i++) begin
      sdi = d[7 - (i % 8)];
      tick(4);
      r = {r[6:0], sdo};
      sck = 1;
      tick(4);
      sck = 0;
    end
    tick(2);
  endtask

  task automatic open_reg();  cs_reg_n = 0;  tick(2); endtask
  task automatic open_fifo(); cs_fifo_n = 0; tick(2); endtask
  task automatic close_all(); cs_reg_n = 1; cs_fifo_n = 1; tick(4); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++; compared++;
      $display("FIFO-PORT FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    tick(3);
    // R1 reset state
    chk({reg_wr, reg_rd, fifo_push, fifo_pop, fifo_clr, fifo_ovr, sdo_oe}, 0, "R1 reset outputs");
    rst_n = 1; tick(3);
    chk({reg_wr, reg_rd, fifo_push, fifo_pop, fifo_clr, fifo_ovr, sdo_oe}, 0, "R1 after release");

    // R2 write: addr 0x03 -> byte 8'h06, data A5
    q_wr.push_back({5'h03, 8'hA5});
    open_reg(); chk(sdo_oe, 1, "R11 enabled");
    bits(8'h06, 8, r); bits(8'hA5, 8, r); close_all();
    chk(q_wr.size(), 0, "R2 write seen");

    // R3 R4 streaming read: addr 7, then 9, then 0
    q_rd.push_back(5'h07); q_rd.push_back(5'h09); q_rd.push_back(5'h00);
    open_reg();
    bits(8'h4E, 8, r);
    bits(8'h12, 8, r); chk(r, rd_val(5'h07), "R3 read data on sdo");
    bits(8'h00, 8, r); chk(r, rd_val(5'h09), "R4 second read data");
    close_all();
    chk(q_rd.size(), 0, "R4 all reads issued");

    // R5 address-only frame, then a fresh pair
    open_reg(); bits(8'h0A, 8, r); close_all();
    q_wr.push_back({5'h06, 8'h33});
    open_reg(); bits(8'h0C, 8, r); bits(8'h33, 8, r); close_all();
    chk(q_wr.size(), 0, "R5 fresh address phase");

    // R6 FIFO write frames of 8, 12 and 5 bits
    fifo_rd_mode = 0;
    q_push.push_back(8'hC3);
    open_fifo(); bits(8'hC3, 8, r); close_all();
    q_push.push_back(8'h5E);
    open_fifo(); bits(8'h5E, 12, r); close_all();
    open_fifo(); bits(8'hFF, 5, r); close_all();
    chk(q_push.size(), 0, "R6 one push per frame");

    // R7 FIFO read
    fifo_rd_mode = 1; fifo_rdata = 8'h9E; n_pop = 1;
    open_fifo(); bits(8'h00, 8, r); close_all();
    chk(r, 8'h9E, "R7 popped byte on sdo");
    chk(n_pop, 0, "R7 one pop");

    // R8 overrun
    fifo_rd_mode = 0; fifo_full = 1;
    open_fifo(); bits(8'h11, 8, r); close_all();
    chk(fifo_ovr, 1, "R8 flag set");
    fifo_full = 0; q_push.push_back(8'h22);
    open_fifo(); bits(8'h22, 8, r); close_all();
    chk(fifo_ovr, 1, "R8 flag sticky");

    // R9 clear with bit0 = 0 keeps flag, bit0 = 1 clears
    q_wr.push_back({5'h0D, 8'h02});
    open_reg(); bits(8'h1A, 8, r); bits(8'h02, 8, r); close_all();
    chk(fifo_ovr, 1, "R9 no clear without bit0");
    q_wr.push_back({5'h0D, 8'h01}); n_clr = 1;
    open_reg(); bits(8'h1A, 8, r); bits(8'h01, 8, r); close_all();
    chk(fifo_ovr, 0, "R9 flag cleared");
    chk(n_clr, 0, "R9 clear pulse");

    // R10 both selects low: register wins, no pop or push
    fifo_rd_mode = 1;
    q_wr.push_back({5'h0B, 8'h77});
    cs_reg_n = 0; cs_fifo_n = 0; tick(2);
    bits(8'h16, 8, r); bits(8'h77, 8, r); close_all();
    fifo_rd_mode = 0;
    cs_reg_n = 0; cs_fifo_n = 0; tick(2);
    q_wr.push_back({5'h01, 8'h44});
    bits(8'h02, 8, r); bits(8'h44, 8, r); close_all();
    chk(q_wr.size(), 0, "R10 register transfer done");
    chk(q_push.size(), 0, "R10 no push");
    chk(fifo_ovr, 0, "R10 flag untouched");
    chk(sdo_oe, 0, "R11 disabled when idle");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule